// File: doc/BRIEF.md
# DDR Command Word Sequencer

This block drives a DRAM command bus from a short queue of 32-bit command words. A host pushes the words through a write port and then raises a start input. The block pops one word at a time and turns it into a pin-level command: chip select, row strobe, column strobe, write enable, bank address and address bus. It also keeps the clock-enable and device-reset pins. Software uses the queue to bring up a DDR2 or DDR3 device and to issue maintenance commands.

Wait-type words place a NOP or a deselect on the bus and hold it for a 29-bit clock count, so that the host can program every power-up and mode-register delay. Two of these wait forms also raise clock enable. When the queue has run dry and the last word has finished, the block raises a sticky done interrupt. A word it does not recognise sets a sticky error interrupt.

Top module: `ddr_cmd_seq`

## Requirements
- R1: After reset the bus is deselected ({cs_n,ras_n,cas_n,we_n}=1111), ba and addr are zero, cke is low, reset_n is low, empty is high, and done_irq and err_irq are low.
- R2: Words run in the order they were pushed. A push while full is high is dropped. full is high when DEPTH words are stored. empty is high when no word is stored.
- R3: No word is popped while start is low. The bus stays deselected and empty holds its value.
- R4: When a word has bits [31:29] equal to 000, the block drives deselect (1111). When they are 001, it drives NOP (0111). The chosen command lasts for 1 + bits[28:0] clocks and cke keeps its level.
- R5: When bits [31:29] are 010, the block drives deselect. When they are 011, it drives NOP. The timing is the same as in R4. cke goes high in the first clock of the word and then stays high.
- R6: Bits [31:27]=10000 drive precharge-all (0010) with addr bit 10 set, for one clock.
- R7: Bits [31:27]=10001 drive a mode-register write (0000) for one clock. ba takes bits [17:16] and addr takes bits [15:0].
- R8: Bits [31:27]=10010 drive auto-refresh (0001) for one clock.
- R9: Bits [31:27]=10110 drive NOP for one clock. reset_n goes high in that clock and then stays high.
- R10: Bits [31:27]=10111 drive long ZQ calibration (0110) with addr bit 10 set, for one clock.
- R11: Any other word with bit 31 set drives NOP for one clock and sets err_irq. err_irq stays set until err_clr is pulsed.
- R12: The clock after the final word's span, with the queue empty, the bus returns to deselect and done_irq rises. done_irq stays high until done_clr is pulsed.
- R13: When a word ends and more words are queued with start high, the next word follows in the very next clock with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Push wr_data into the queue |
| wr_data | input | 32 | Command word |
| start | input | 1 | Allow the queue to drain |
| done_clr | input | 1 | Clear done_irq |
| err_clr | input | 1 | Clear err_irq |
| full | output | 1 | Queue full |
| empty | output | 1 | Queue empty |
| done_irq | output | 1 | Sticky completion interrupt |
| err_irq | output | 1 | Sticky undefined-word interrupt |
| cs_n | output | 1 | Chip select, low active |
| ras_n | output | 1 | Row strobe, low active |
| cas_n | output | 1 | Column strobe, low active |
| we_n | output | 1 | Write enable, low active |
| cke | output | 1 | Clock enable, latched |
| reset_n | output | 1 | Device reset, latched high once released |
| ba | output | BA_W | Bank address |
| addr | output | AW | Address bus |

## Verification
The bench sweeps all four wait codes with counts from 0 to 5. An off-by-one in the count would show up as a command one clock too short or too long, and it would shift every later word. It runs full bring-up sequences back to back. If the block inserted an idle gap between words, or dropped the address on a mode-register write, every cycle after that point would mismatch. It overfills the queue, holds start low, and sends undefined codes. These checks catch a queue that overwrites its stored words, a block that drains without start, and cke, reset_n or the two interrupts failing to stay latched.

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq #(
  parameter int DEPTH = 8,
  parameter int BA_W  = 3,
  parameter int AW    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  input  logic            start,
  input  logic            done_clr,
  input  logic            err_clr,
  output logic            full,
  output logic            empty,
  output logic            done_irq,
  output logic            err_irq,
  output logic            cs_n,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n,
  output logic            cke,
  output logic            reset_n,
  output logic [BA_W-1:0] ba,
  output logic [AW-1:0]   addr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = 29;
  localparam logic [PW:0]   LVL_MAX  = (PW+1)'(DEPTH);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH-1);
  localparam logic [3:0]    P_DES    = 4'b1111;
  localparam logic [3:0]    P_NOP    = 4'b0111;

  logic [31:0]     mem [DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [PW:0]     lvl;
  logic [CW-1:0]   wait_q;
  logic            busy_q, cke_q, rst_q, done_q, err_q;
  logic [3:0]      pins_q;
  logic [AW-1:0]   addr_q;
  logic [BA_W-1:0] ba_q;

  assign full  = (lvl == LVL_MAX);
  assign empty = (lvl == '0);

  wire        push = wr_en && !full;
  wire        pop  = start && !empty && (wait_q == '0);
  wire [31:0] head = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      lvl <= '0;
    end else begin
      if (push) wp <= (wp == PTR_LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PTR_LAST) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   lvl <= lvl + 1'b1;
        2'b01:   lvl <= lvl - 1'b1;
        default: lvl <= lvl;
      endcase
    end
  end

  logic [3:0]      d_pins;
  logic [AW-1:0]   d_addr;
  logic [BA_W-1:0] d_ba;
  logic [CW-1:0]   d_wait;
  logic            d_cke, d_rst, d_bad;

  always_comb begin
    d_pins = P_NOP;
    d_addr = '0;
    d_ba   = '0;
    d_wait = '0;
    d_cke  = 1'b0;
    d_rst  = 1'b0;
    d_bad  = 1'b0;
    if (!head[31]) begin
      d_pins = head[29] ? P_NOP : P_DES;
      d_cke  = head[30];
      d_wait = head[CW-1:0];
    end else begin
      case (head[31:27])
        5'b10000: begin d_pins = 4'b0010; d_addr = AW'(16'h0400); end
        5'b10001: begin
          d_pins = 4'b0000;
          d_ba   = BA_W'(head[17:16]);
          d_addr = AW'(head[15:0]);
        end
        5'b10010: d_pins = 4'b0001;
        5'b10110: d_rst  = 1'b1;
        5'b10111: begin d_pins = 4'b0110; d_addr = AW'(16'h0400); end
        default:  d_bad  = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= P_DES;
      addr_q <= '0;
      ba_q   <= '0;
      wait_q <= '0;
      busy_q <= 1'b0;
      cke_q  <= 1'b0;
      rst_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (pop) begin
        pins_q <= d_pins;
        addr_q <= d_addr;
        ba_q   <= d_ba;
        wait_q <= d_wait;
        busy_q <= 1'b1;
      end else if (wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
      end else begin
        pins_q <= P_DES;
        addr_q <= '0;
        ba_q   <= '0;
        busy_q <= 1'b0;
      end
      cke_q  <= cke_q | (pop & d_cke);
      rst_q  <= rst_q | (pop & d_rst);
      err_q  <= (err_q & !err_clr) | (pop & d_bad);
      done_q <= (done_q & !done_clr) | (!pop && wait_q == '0 && busy_q && empty);
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = pins_q;
  assign addr     = addr_q;
  assign ba       = ba_q;
  assign cke      = cke_q;
  assign reset_n  = rst_q;
  assign done_irq = done_q;
  assign err_irq  = err_q;
endmodule

// File: rtl/ddr_cmd_seq_chk.sv
module ddr_cmd_seq_chk #(
  parameter int BA_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            start,
  input logic            done_clr,
  input logic            err_clr,
  input logic            empty,
  input logic            full,
  input logic            done_irq,
  input logic            err_irq,
  input logic            cs_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic            cke,
  input logic            reset_n,
  input logic [BA_W-1:0] ba
);
  p_hold_without_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !wr_en) |=> $stable(empty));

  p_full_not_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  p_cke_latched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  p_reset_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_n |=> reset_n);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_irq && !err_clr) |=> err_irq);

  p_done_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq && !done_clr) |=> done_irq);

  p_bank_only_on_mrs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ba != '0) |-> (!cs_n && !ras_n && !cas_n && !we_n));
endmodule

bind ddr_cmd_seq ddr_cmd_seq_chk #(.BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .start(start),
  .done_clr(done_clr), .err_clr(err_clr), .empty(empty), .full(full),
  .done_irq(done_irq), .err_irq(err_irq), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .cke(cke), .reset_n(reset_n), .ba(ba)
);

// File: tb/sim_ddr_cmd_seq.sv
`timescale 1ns/1ps
module sim_ddr_cmd_seq;
  localparam int DEPTH = 8;
  localparam int BA_W  = 3;
  localparam int AW    = 16;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, start = 1'b0;
  logic done_clr = 1'b0, err_clr = 1'b0;
  logic [31:0] wr_data = '0;
  logic full, empty, done_irq, err_irq, cs_n, ras_n, cas_n, we_n, cke, reset_n;
  logic [BA_W-1:0] ba;
  logic [AW-1:0] addr;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] wl [32];
  logic cke_e = 1'b0, rst_e = 1'b0, err_e = 1'b0;

  always #2.5 clk = ~clk;

  ddr_cmd_seq #(.DEPTH(DEPTH), .BA_W(BA_W), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .start(start),
    .done_clr(done_clr), .err_clr(err_clr), .full(full), .empty(empty),
    .done_irq(done_irq), .err_irq(err_irq), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .cke(cke), .reset_n(reset_n), .ba(ba), .addr(addr)
  );

  function automatic logic [27:0] act();
    return {cs_n, ras_n, cas_n, we_n, cke, reset_n, ba, addr, empty, done_irq, err_irq};
  endfunction

  task automatic cmp(input string r, input logic [63:0] a, input logic [63:0] e);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", r, a, e);
    end
  endtask

  // Expected behaviour of one word, worked out from the requirements
  task automatic expd(input logic [31:0] w, output logic [3:0] p, output logic [BA_W-1:0] b,
                      output logic [AW-1:0] a, output int wt, output string r);
    p = 4'b0111; b = '0; a = '0; wt = 0; r = "R11";
    if (!w[31]) begin
      p  = w[29] ? 4'b0111 : 4'b1111;
      wt = int'(w[28:0]);
      r  = w[30] ? "R5" : "R4";
      if (w[30]) cke_e = 1'b1;
    end else begin
      case (w[31:27])
        5'b10000: begin p = 4'b0010; a = 16'h0400; r = "R6"; end
        5'b10001: begin p = 4'b0000; b = BA_W'(w[17:16]); a = w[15:0]; r = "R7"; end
        5'b10010: begin p = 4'b0001; r = "R8"; end
        5'b10110: begin rst_e = 1'b1; r = "R9"; end
        5'b10111: begin p = 4'b0110; a = 16'h0400; r = "R10"; end
        default:  err_e = 1'b1;
      endcase
    end
  endtask

  task automatic push(input logic [31:0] w);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    logic [3:0] p; logic [BA_W-1:0] b; logic [AW-1:0] a; int wt; string r;
    start = 1'b1;
    for (int k = 0; k < n; k++) begin
      expd(wl[k], p, b, a, wt, r);
      for (int c = 0; c <= wt; c++) begin
        @(negedge clk);
        cmp((k > 0 && c == 0) ? {r, "/R13/R2"} : r, 64'(act()),
            64'({p, cke_e, rst_e, b, a, (k == n-1), 1'b0, err_e}));
      end
    end
    @(negedge clk);
    cmp("R12 end", 64'(act()), 64'({4'b1111, cke_e, rst_e, 3'b0, 16'h0, 1'b1, 1'b1, err_e}));
    start = 1'b0;
    repeat (3) begin
      @(negedge clk);
      cmp("R12 sticky", 64'(done_irq), 64'(1));
    end
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    cmp("R12 clear", 64'(done_irq), 64'(0));
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog R12 act=hung exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1", 64'(act()), 64'({4'b1111, 1'b0, 1'b0, 3'b0, 16'h0, 1'b1, 1'b0, 1'b0}));
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 after release", 64'(act()), 64'({4'b1111, 1'b0, 1'b0, 3'b0, 16'h0, 1'b1, 1'b0, 1'b0}));

    // R3: queued words wait for start
    wl[0] = 32'h2000_0001; wl[1] = 32'h0000_0000;
    push(wl[0]); push(wl[1]);
    repeat (5) begin
      @(negedge clk);
      cmp("R3", 64'(act()), 64'({4'b1111, 1'b0, 1'b0, 3'b0, 16'h0, 1'b0, 1'b0, 1'b0}));
    end
    run(2);

    // R4/R5 sweep: every wait code, counts 0..5
    for (int code = 0; code < 4; code++) begin
      for (int c = 0; c < 6; c++) begin
        wl[c] = {3'(code), 29'(c)};
        push(wl[c]);
      end
      run(6);
    end

    // DDR3-style bring-up
    wl[0] = 32'h2000_0003; wl[1] = 32'hB000_0000; wl[2] = 32'h6000_0002;
    wl[3] = 32'h8802_0010; wl[4] = 32'h2000_0001; wl[5] = 32'h8801_0004;
    wl[6] = 32'h8800_0B50; wl[7] = 32'hB800_0000;
    for (int k = 0; k < 8; k++) push(wl[k]);
    run(8);

    // DDR2-style bring-up
    wl[0] = 32'h0000_0000; wl[1] = 32'h8000_0000; wl[2] = 32'h2000_0002;
    wl[3] = 32'h9000_0000; wl[4] = 32'h9000_0000; wl[5] = 32'h8803_FFFF;
    wl[6] = 32'h8800_0A53;
    for (int k = 0; k < 7; k++) push(wl[k]);
    run(7);

    // R11: undefined words
    wl[0] = 32'h9800_0000; wl[1] = 32'hA000_0000; wl[2] = 32'hF800_0001;
    wl[3] = 32'h2000_0000;
    for (int k = 0; k < 4; k++) push(wl[k]);
    run(4);
    cmp("R11 sticky", 64'(err_irq), 64'(1));
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    err_e = 1'b0;
    cmp("R11 clear", 64'(err_irq), 64'(0));

    // Long wait
    wl[0] = 32'h2000_0032;
    push(wl[0]);
    run(1);

    // R2: overflow drops extra pushes
    for (int k = 0; k < DEPTH + 2; k++) begin
      if (k < DEPTH) wl[k] = 32'h2000_0000 | 32'(k);
      push(32'h2000_0000 | 32'(k));
      if (k == DEPTH - 1) cmp("R2 full", 64'(full), 64'(1));
    end
    cmp("R2 still full", 64'(full), 64'(1));
    run(DEPTH);
    cmp("R2 not full", 64'(full), 64'(0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule